// File: doc/BRIEF.md
# SD card SPI-mode start-up sequencer

This block takes a freshly powered memory card from its native bus mode into SPI mode and leaves it ready for 512-byte block transfers. It does not shift bits itself. It drives a separate command engine, which frames and transmits commands and collects responses. It also drives a raw byte port, which sends the wake-up clocks with chip select held high by that port. A clock-select output tells the serial clock generator when the slow identification rate can be replaced by the fast data rate.

A `start_i` pulse begins the sequence. The sequencer sends the wake-up bytes and then issues the reset command. It then probes the interface condition with CMD8 and, from that answer, takes one of two branches. The first branch is the older standard-capacity loop. The second branch is the newer loop that polls the operating-condition register and waits a programmable time between attempts. Both branches end by fixing the block length and switching to the fast clock.

At the end, the block reports one of two results. On success it gives the card generation and whether the card is addressed by block or by byte. On failure it raises a failure flag. A status output stays at "not initialized" until success. A later `start_i` runs the whole sequence again.

Top module: `sdspi_boot_seq`

## Requirements
- R1: After reset, `not_init_o`=1, `ready_o`=0, `fail_o`=0, `clk_fast_o`=0 (slow clock), `cmd_req_o`=0, `wake_valid_o`=0 and `card_type_o`=0.
- R2: After `start_i`, exactly WAKE_BYTES bytes of 0xFF are accepted on the wake port (`wake_valid_o` and `wake_ready_i` both high) with the slow clock selected, before the first command request. A byte stays offered until it is accepted.
- R3: The first command is index 0 with argument 0. Its R1 must be exactly 0x01, otherwise the sequence fails and issues no further command.
- R4: The second command is index 8 with argument 0x000001AA. An R1 of 0x01 selects the newer branch, an R1 of 0x05 selects the older branch, and any other value fails.
- R5: The older branch repeats index 55 (argument 0) followed by index 41 (argument 0) until the index-41 R1 is 0x00. It then reports `card_type_o`=1 and `blk_addr_o`=0 (byte addressing, block number times 512).
- R6: The newer branch repeats a wait of at least RETRY_DELAY cycles, index 58, index 55 and then index 41 with argument 0x40000000, until the index-41 R1 is 0x00. It then issues one more index 58. It reports `card_type_o`=2 and sets `blk_addr_o` to bit 30 of that final trailer.
- R7: If the index-41 R1 is nonzero on POLL_LIMIT consecutive attempts, the sequence fails. It never makes more than POLL_LIMIT attempts.
- R8: The last command is index 16 with argument 512. A nonzero R1 fails. An R1 of zero gives `ready_o`=1, `not_init_o`=0 and `clk_fast_o`=1, and the fast clock is never selected unless ready.
- R9: A completion with `cmd_timeout_i`=1 at any step ends the sequence in failure, and no further command is issued.
- R10: `start_i` is ignored while a sequence is running. From the ready or failed state, `start_i` restarts the sequence, with `not_init_o` back to 1 and the slow clock selected on the next cycle.
- R11: `cmd_req_o` is a one-cycle pulse, with `cmd_idx_o`, `cmd_arg_o` and `cmd_trailer_o` valid alongside it. At most one command is outstanding. `cmd_trailer_o` is 1 exactly for indices 8 and 58.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to run the start-up sequence |
| wake_valid_o | output | 1 | Wake-up byte offered (chip select held high by the byte port) |
| wake_byte_o | output | 8 | Wake-up byte value, always 0xFF |
| wake_ready_i | input | 1 | Byte port accepts the offered byte |
| cmd_req_o | output | 1 | One-cycle command request |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_trailer_o | output | 1 | Engine must collect a 32-bit trailer after R1 |
| cmd_done_i | input | 1 | Command completed, response valid this cycle |
| cmd_r1_i | input | 8 | R1 status byte |
| cmd_timeout_i | input | 1 | Engine saw no response |
| cmd_trailer_i | input | 32 | Trailer word following R1 |
| clk_fast_o | output | 1 | 0 selects the slow identification clock, 1 the fast data clock |
| ready_o | output | 1 | Sequence finished successfully |
| fail_o | output | 1 | Sequence ended in failure |
| not_init_o | output | 1 | Status: 1 until a sequence has completed successfully |
| card_type_o | output | 2 | 0 unknown, 1 older standard capacity, 2 newer generation |
| blk_addr_o | output | 1 | 1 when the card is addressed by block number |

## Verification
The hardest situations to reach from the ports are exhaustion of the poll loop and the enforced gap between newer-branch attempts. Both need the card to keep answering "busy" many times in a row. The bench's responder model can be told how many index-41 replies should report busy, whether to time out on a given index, and which bit to place in the trailer. The bench instance also lowers POLL_LIMIT and RETRY_DELAY, so exhaustion and the gap can be measured within a short run. The gap is checked by timestamping each request the model sees.

// File: rtl/sdspi_boot_pkg.sv
package sdspi_boot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAKE,
        ST_GO_IDLE,
        ST_IF_COND,
        ST_V1_APP,
        ST_V1_OP,
        ST_V2_WAIT,
        ST_V2_OCR,
        ST_V2_APP,
        ST_V2_OP,
        ST_V2_FIN,
        ST_SET_BLK,
        ST_READY,
        ST_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        CARD_NONE = 2'd0,
        CARD_V1   = 2'd1,
        CARD_V2   = 2'd2
    } card_e;

    localparam logic [5:0]  IDX_GO_IDLE = 6'd0;
    localparam logic [5:0]  IDX_IF_COND = 6'd8;
    localparam logic [5:0]  IDX_BLKLEN  = 6'd16;
    localparam logic [5:0]  IDX_OP_COND = 6'd41;
    localparam logic [5:0]  IDX_APP     = 6'd55;
    localparam logic [5:0]  IDX_RD_OCR  = 6'd58;

    localparam logic [31:0] ARG_IF_COND = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS     = 32'h4000_0000;
    localparam logic [31:0] ARG_BLKLEN  = 32'd512;

    localparam logic [7:0]  R1_IDLE     = 8'h01;
    localparam logic [7:0]  R1_IDLE_ILL = 8'h05;
    localparam logic [7:0]  R1_OK       = 8'h00;

    typedef struct packed {
        seq_state_e  state;
        logic        busy;
        logic        req;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic        trl;
        card_e       card;
        logic        blk;
        logic        fast;
    } seq_ctl_t;

endpackage

// File: rtl/sdspi_wake_gen.sv
module sdspi_wake_gen #(
    parameter int BYTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic ready_i,
    output logic valid_o,
    output logic done_o
);
    localparam int CW = $clog2(BYTES + 1);

    logic          active_d, active_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          last;

    assign last    = (cnt_q == CW'(BYTES - 1));
    assign valid_o = active_q;
    assign done_o  = active_q && ready_i && last;

    always_comb begin
        active_d = active_q;
        cnt_d    = cnt_q;
        if (go_i) begin
            active_d = 1'b1;
            cnt_d    = '0;
        end else if (active_q && ready_i) begin
            if (last) active_d = 1'b0;
            else      cnt_d    = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            active_q <= active_d;
            cnt_q    <= cnt_d;
        end
    end

    // byte count never runs past the configured number of wake bytes
    assert_wake_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BYTES - 1));
    // an offered byte is not withdrawn before it is taken
    assert_wake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !go_i) |=> valid_o);

endmodule

// File: rtl/sdspi_retry_timer.sv
module sdspi_retry_timer #(
    parameter int DELAY = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic expired_o
);
    localparam int DW = $clog2(DELAY + 1);

    logic          run_d, run_q;
    logic [DW-1:0] cnt_d, cnt_q;

    assign expired_o = run_q && (cnt_q == '0);

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (go_i) begin
            run_d = 1'b1;
            cnt_d = DW'(DELAY - 1);
        end else if (run_q) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    // the wait counts down by exactly one each cycle until it expires
    assert_delay_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !go_i) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdspi_poll_ctr.sv
module sdspi_poll_ctr #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                cnt_d = '0;
        else if (inc_i && !last_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // attempt count stays below the poll limit
    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/sdspi_boot_seq.sv
module sdspi_boot_seq
    import sdspi_boot_pkg::*;
#(
    parameter int WAKE_BYTES  = 16,
    parameter int POLL_LIMIT  = 5000,
    parameter int RETRY_DELAY = 400000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        wake_valid_o,
    output logic [7:0]  wake_byte_o,
    input  logic        wake_ready_i,
    output logic        cmd_req_o,
    output logic [5:0]  cmd_idx_o,
    output logic [31:0] cmd_arg_o,
    output logic        cmd_trailer_o,
    input  logic        cmd_done_i,
    input  logic [7:0]  cmd_r1_i,
    input  logic        cmd_timeout_i,
    input  logic [31:0] cmd_trailer_i,
    output logic        clk_fast_o,
    output logic        ready_o,
    output logic        fail_o,
    output logic        not_init_o,
    output logic [1:0]  card_type_o,
    output logic        blk_addr_o
);
    seq_ctl_t d, q;

    logic wake_go, wake_done;
    logic dly_go, dly_exp;
    logic poll_clr, poll_inc, poll_last;
    logic unused_trl;

    assign unused_trl = ^{cmd_trailer_i[31], cmd_trailer_i[29:0]};

    sdspi_wake_gen #(.BYTES(WAKE_BYTES)) u_wake (
        .clk(clk), .rst_n(rst_n), .go_i(wake_go), .ready_i(wake_ready_i),
        .valid_o(wake_valid_o), .done_o(wake_done)
    );

    sdspi_retry_timer #(.DELAY(RETRY_DELAY)) u_dly (
        .clk(clk), .rst_n(rst_n), .go_i(dly_go), .expired_o(dly_exp)
    );

    sdspi_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr_i(poll_clr), .inc_i(poll_inc),
        .last_o(poll_last)
    );

    function automatic logic is_cmd_state(input seq_state_e s);
        return (s == ST_GO_IDLE) || (s == ST_IF_COND) || (s == ST_V1_APP) ||
               (s == ST_V1_OP)   || (s == ST_V2_OCR)  || (s == ST_V2_APP) ||
               (s == ST_V2_OP)   || (s == ST_V2_FIN)  || (s == ST_SET_BLK);
    endfunction

    function automatic logic [5:0] idx_of(input seq_state_e s);
        case (s)
            ST_GO_IDLE:           return IDX_GO_IDLE;
            ST_IF_COND:           return IDX_IF_COND;
            ST_V1_APP, ST_V2_APP: return IDX_APP;
            ST_V1_OP, ST_V2_OP:   return IDX_OP_COND;
            ST_V2_OCR, ST_V2_FIN: return IDX_RD_OCR;
            default:              return IDX_BLKLEN;
        endcase
    endfunction

    function automatic logic [31:0] arg_of(input seq_state_e s);
        case (s)
            ST_IF_COND: return ARG_IF_COND;
            ST_V2_OP:   return ARG_HCS;
            ST_SET_BLK: return ARG_BLKLEN;
            default:    return 32'd0;
        endcase
    endfunction

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        wake_go  = 1'b0;
        dly_go   = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;

        if (is_cmd_state(q.state)) begin
            if (!q.busy) begin
                d.busy = 1'b1;
                d.req  = 1'b1;
                d.idx  = idx_of(q.state);
                d.arg  = arg_of(q.state);
                d.trl  = (idx_of(q.state) == IDX_IF_COND) ||
                         (idx_of(q.state) == IDX_RD_OCR);
            end else if (cmd_done_i) begin
                d.busy = 1'b0;
                if (cmd_timeout_i) begin
                    d.state = ST_FAIL;
                end else begin
                    case (q.state)
                        ST_GO_IDLE:
                            d.state = (cmd_r1_i == R1_IDLE) ? ST_IF_COND : ST_FAIL;
                        ST_IF_COND: begin
                            poll_clr = 1'b1;
                            if (cmd_r1_i == R1_IDLE) begin
                                d.state = ST_V2_WAIT;
                                dly_go  = 1'b1;
                            end else if (cmd_r1_i == R1_IDLE_ILL) begin
                                d.state = ST_V1_APP;
                            end else begin
                                d.state = ST_FAIL;
                            end
                        end
                        ST_V1_APP: d.state = ST_V1_OP;
                        ST_V1_OP: begin
                            if (cmd_r1_i == R1_OK) begin
                                d.state = ST_SET_BLK;
                                d.card  = CARD_V1;
                                d.blk   = 1'b0;
                            end else if (poll_last) begin
                                d.state = ST_FAIL;
                            end else begin
                                poll_inc = 1'b1;
                                d.state  = ST_V1_APP;
                            end
                        end
                        ST_V2_OCR: d.state = ST_V2_APP;
                        ST_V2_APP: d.state = ST_V2_OP;
                        ST_V2_OP: begin
                            if (cmd_r1_i == R1_OK) begin
                                d.state = ST_V2_FIN;
                            end else if (poll_last) begin
                                d.state = ST_FAIL;
                            end else begin
                                poll_inc = 1'b1;
                                dly_go   = 1'b1;
                                d.state  = ST_V2_WAIT;
                            end
                        end
                        ST_V2_FIN: begin
                            d.state = ST_SET_BLK;
                            d.card  = CARD_V2;
                            d.blk   = cmd_trailer_i[30];
                        end
                        default: begin
                            if (cmd_r1_i == R1_OK) begin
                                d.state = ST_READY;
                                d.fast  = 1'b1;
                            end else begin
                                d.state = ST_FAIL;
                            end
                        end
                    endcase
                end
            end
        end else begin
            case (q.state)
                ST_IDLE, ST_READY, ST_FAIL: begin
                    if (start_i) begin
                        d.state = ST_WAKE;
                        d.card  = CARD_NONE;
                        d.blk   = 1'b0;
                        d.fast  = 1'b0;
                        wake_go = 1'b1;
                    end
                end
                ST_WAKE:    if (wake_done) d.state = ST_GO_IDLE;
                ST_V2_WAIT: if (dly_exp)   d.state = ST_V2_OCR;
                default:    d.state = ST_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.busy  <= 1'b0;
            q.req   <= 1'b0;
            q.idx   <= '0;
            q.arg   <= '0;
            q.trl   <= 1'b0;
            q.card  <= CARD_NONE;
            q.blk   <= 1'b0;
            q.fast  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wake_byte_o   = 8'hFF;
    assign cmd_req_o     = q.req;
    assign cmd_idx_o     = q.idx;
    assign cmd_arg_o     = q.arg;
    assign cmd_trailer_o = q.trl;
    assign clk_fast_o    = q.fast;
    assign ready_o       = (q.state == ST_READY);
    assign fail_o        = (q.state == ST_FAIL);
    assign not_init_o    = (q.state != ST_READY);
    assign card_type_o   = q.card;
    assign blk_addr_o    = q.blk;

    // request is a single-cycle pulse
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_o |=> !cmd_req_o);
    // no command is requested while wake bytes are still flowing
    assert_no_cmd_in_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid_o |-> (!cmd_req_o && !clk_fast_o));
    // fast clock only once the sequence has completed
    assert_fast_only_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fast_o |-> ready_o);
    // a failed sequence stays silent on the command interface
    assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !cmd_req_o);
    // an older-generation card is always byte addressed
    assert_v1_byte_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (card_type_o == 2'd1) |-> !blk_addr_o);
    // a timed-out command never leads to another request
    assert_timeout_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_i && cmd_timeout_i && q.busy) |=> fail_o);

endmodule

// File: tb/sdspi_boot_seq_bench.sv
`timescale 1ns/1ps
module sdspi_boot_seq_bench;
    localparam int WB = 16;
    localparam int PL = 8;
    localparam int RD = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wake_valid_o, wake_ready_i;
    logic [7:0]  wake_byte_o;
    logic        cmd_req_o, cmd_trailer_o;
    logic [5:0]  cmd_idx_o;
    logic [31:0] cmd_arg_o;
    logic        cmd_done_i = 1'b0;
    logic [7:0]  cmd_r1_i = 8'hFF;
    logic        cmd_timeout_i = 1'b0;
    logic [31:0] cmd_trailer_i = 32'd0;
    logic        clk_fast_o, ready_o, fail_o, not_init_o, blk_addr_o;
    logic [1:0]  card_type_o;

    always #2.5 clk = ~clk;

    sdspi_boot_seq #(.WAKE_BYTES(WB), .POLL_LIMIT(PL), .RETRY_DELAY(RD)) u_sdspi_boot_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .wake_valid_o(wake_valid_o), .wake_byte_o(wake_byte_o), .wake_ready_i(wake_ready_i),
        .cmd_req_o(cmd_req_o), .cmd_idx_o(cmd_idx_o), .cmd_arg_o(cmd_arg_o),
        .cmd_trailer_o(cmd_trailer_o), .cmd_done_i(cmd_done_i), .cmd_r1_i(cmd_r1_i),
        .cmd_timeout_i(cmd_timeout_i), .cmd_trailer_i(cmd_trailer_i),
        .clk_fast_o(clk_fast_o), .ready_o(ready_o), .fail_o(fail_o),
        .not_init_o(not_init_o), .card_type_o(card_type_o), .blk_addr_o(blk_addr_o)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int wake_cnt = 0, wake_bad = 0, req_bad = 0, trl_bad = 0;
    logic prev_req = 1'b0;

    int          n_cmd = 0;
    logic [5:0]  idx_log [0:63];
    logic [31:0] arg_log [0:63];
    int          t_log   [0:63];
    int          cmd_at_first = -1;

    logic [7:0] cfg_r0, cfg_r8, cfg_r16;
    int         cfg_busy, cfg_to, acmd_cnt;
    logic       cfg_ccs;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: wake bytes, request pulse width, trailer flag
    initial begin
        wake_ready_i = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (wake_valid_o && wake_ready_i) begin
                wake_cnt++;
                if (wake_byte_o != 8'hFF || clk_fast_o || n_cmd != 0) wake_bad++;
            end
            if (cmd_req_o && prev_req) req_bad++;
            if (cmd_req_o && (cmd_trailer_o != (cmd_idx_o == 6'd8 || cmd_idx_o == 6'd58)))
                trl_bad++;
            prev_req = cmd_req_o;
            wake_ready_i = ~wake_ready_i;
        end
    end

    // command engine model
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_req_o) begin
                logic [5:0] ix;
                ix = cmd_idx_o;
                if (n_cmd < 64) begin
                    idx_log[n_cmd] = cmd_idx_o;
                    arg_log[n_cmd] = cmd_arg_o;
                    t_log[n_cmd]   = cyc;
                end
                n_cmd++;
                @(negedge clk);
                @(negedge clk);
                cmd_timeout_i = (int'(ix) == cfg_to);
                cmd_trailer_i = 32'h00FF_8000;
                case (ix)
                    6'd0:  cmd_r1_i = cfg_r0;
                    6'd8:  begin cmd_r1_i = cfg_r8; cmd_trailer_i = 32'h0000_01AA; end
                    6'd16: cmd_r1_i = cfg_r16;
                    6'd41: begin
                        if (acmd_cnt < cfg_busy) cmd_r1_i = 8'h01;
                        else                     cmd_r1_i = 8'h00;
                        acmd_cnt++;
                    end
                    6'd58: begin cmd_r1_i = 8'h01; cmd_trailer_i[30] = cfg_ccs; end
                    default: cmd_r1_i = 8'h01;
                endcase
                cmd_done_i = 1'b1;
                @(negedge clk);
                cmd_done_i    = 1'b0;
                cmd_timeout_i = 1'b0;
            end
        end
    end

    task automatic prep(input logic [7:0] r0, input logic [7:0] r8, input int busy,
                        input logic [7:0] r16, input logic ccs, input int to_idx);
        cfg_r0 = r0; cfg_r8 = r8; cfg_busy = busy; cfg_r16 = r16;
        cfg_ccs = ccs; cfg_to = to_idx; acmd_cnt = 0;
        n_cmd = 0; wake_cnt = 0; wake_bad = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_end(input string tag);
        int k;
        k = 0;
        while (!(ready_o || fail_o) && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " finished"}, (k < 5000), 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 not_init", not_init_o, 1);
        chk("R1 ready", ready_o, 0);
        chk("R1 fail", fail_o, 0);
        chk("R1 clk_fast", clk_fast_o, 0);
        chk("R1 req", cmd_req_o, 0);
        chk("R1 wake_valid", wake_valid_o, 0);
        chk("R1 card_type", card_type_o, 0);
    endtask

    task automatic t_v2_busy();
        int exp_idx [13] = '{0, 8, 58, 55, 41, 58, 55, 41, 58, 55, 41, 58, 16};
        prep(8'h01, 8'h01, 2, 8'h00, 1'b1, -1);
        pulse_start();
        wait_end("R6 v2");
        chk("R2 wake count", wake_cnt, WB);
        chk("R2 wake bytes clean", wake_bad, 0);
        chk("R6 v2 cmd count", n_cmd, 13);
        for (int i = 0; i < 13; i++) chk("R6 v2 cmd order", idx_log[i], exp_idx[i]);
        chk("R3 cmd0 arg", arg_log[0], 0);
        chk("R4 cmd8 arg", arg_log[1], 32'h1AA);
        chk("R6 acmd41 arg", arg_log[4], 32'h4000_0000);
        chk("R8 cmd16 arg", arg_log[12], 512);
        chk("R6 retry gap", (t_log[5] - t_log[4] >= RD), 1);
        chk("R6 first gap", (t_log[2] - t_log[1] >= RD), 1);
        chk("R6 card type", card_type_o, 2);
        chk("R6 block addr", blk_addr_o, 1);
        chk("R8 ready", ready_o, 1);
        chk("R8 not_init", not_init_o, 0);
        chk("R8 fast clock", clk_fast_o, 1);
    endtask

    task automatic t_v2_byteaddr();
        prep(8'h01, 8'h01, 0, 8'h00, 1'b0, -1);
        pulse_start();
        wait_end("R6 v2 ccs0");
        chk("R6 ccs0 cmd count", n_cmd, 7);
        chk("R6 ccs0 final ocr", idx_log[5], 58);
        chk("R6 ccs0 block addr", blk_addr_o, 0);
        chk("R6 ccs0 card type", card_type_o, 2);
    endtask

    task automatic t_v1();
        int exp_idx [7] = '{0, 8, 55, 41, 55, 41, 16};
        prep(8'h01, 8'h05, 1, 8'h00, 1'b1, -1);
        pulse_start();
        wait_end("R5 v1");
        chk("R5 v1 cmd count", n_cmd, 7);
        for (int i = 0; i < 7; i++) chk("R5 v1 cmd order", idx_log[i], exp_idx[i]);
        chk("R5 acmd41 arg", arg_log[3], 0);
        chk("R5 card type", card_type_o, 1);
        chk("R5 byte addr", blk_addr_o, 0);
        chk("R8 v1 ready", ready_o, 1);
    endtask

    task automatic t_bad_cmd0();
        prep(8'h00, 8'h01, 0, 8'h00, 1'b0, -1);
        pulse_start();
        wait_end("R3 bad");
        chk("R3 fail", fail_o, 1);
        chk("R3 no further cmd", n_cmd, 1);
        chk("R3 not_init", not_init_o, 1);
        chk("R3 slow clock", clk_fast_o, 0);
    endtask

    task automatic t_bad_cmd8();
        prep(8'h01, 8'h04, 0, 8'h00, 1'b0, -1);
        pulse_start();
        wait_end("R4 bad");
        chk("R4 fail", fail_o, 1);
        chk("R4 no further cmd", n_cmd, 2);
    endtask

    task automatic t_exhaust();
        int n41;
        prep(8'h01, 8'h05, 100, 8'h00, 1'b0, -1);
        pulse_start();
        wait_end("R7 exhaust");
        n41 = 0;
        for (int i = 0; i < 64; i++) if (i < n_cmd && idx_log[i] == 6'd41) n41++;
        chk("R7 fail", fail_o, 1);
        chk("R7 attempts", n41, PL);
        chk("R7 cmd count", n_cmd, 2 + 2 * PL);
    endtask

    task automatic t_cmd16_fail();
        prep(8'h01, 8'h01, 0, 8'h04, 1'b1, -1);
        pulse_start();
        wait_end("R8 bad");
        chk("R8 cmd16 fail", fail_o, 1);
        chk("R8 no fast clock", clk_fast_o, 0);
        chk("R8 still not_init", not_init_o, 1);
    endtask

    task automatic t_timeout();
        prep(8'h01, 8'h05, 0, 8'h00, 1'b0, 55);
        pulse_start();
        wait_end("R9 timeout");
        chk("R9 fail", fail_o, 1);
        chk("R9 cmd count", n_cmd, 3);
        chk("R9 last idx", idx_log[2], 55);
    endtask

    task automatic t_restart();
        prep(8'h01, 8'h05, 0, 8'h00, 1'b0, -1);
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        wait_end("R10 ignore");
        chk("R10 ignored start cmd count", n_cmd, 5);
        chk("R10 ignored start wake", wake_cnt, WB);
        chk("R10 ready", ready_o, 1);
        prep(8'h01, 8'h05, 0, 8'h00, 1'b0, -1);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R10 rerun not_init", not_init_o, 1);
        chk("R10 rerun slow clock", clk_fast_o, 0);
        wait_end("R10 rerun");
        chk("R10 rerun ready", ready_o, 1);
        chk("R10 rerun cmd count", n_cmd, 5);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_v2_busy();
        t_v2_byteaddr();
        t_v1();
        t_bad_cmd0();
        t_bad_cmd8();
        t_exhaust();
        t_cmd16_fail();
        t_timeout();
        t_restart();
        chk("R11 request pulse width", req_bad, 0);
        chk("R11 trailer flag", trl_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule